// File: doc/BRIEF.md
# Interrupt Entry and Program Counter Controller

This block owns the program counter and the one-bit interrupt-enable flag of a small 32-bit, word-addressed multicycle processor. At the first state of every instruction fetch, the fetch sequencer raises a start strobe. The block then decides whether an interrupt must be taken. If no interrupt is due, it reports that at once and fetch continues with no added cycles. If the flag is set and the shared request line is high, it runs a fixed three-cycle entry sequence, and during that sequence it reports busy:
- it writes the current PC into kernel register 12 and clears the enable flag;
- it raises the acknowledge and gates the device ID from the I/O bus onto the vector-table read address;
- it loads the fetched vector into the PC.

The block also carries out the enable, disable and return-from-interrupt instructions, and it accepts ordinary PC loads from the datapath. The PC resets to 0x10. Any stored PC value below 0x10 reads out as 0x10, so execution can never start inside the vector table. Addresses sent to memory keep only their low 24 bits.

Top module: `intr_pc_ctrl`

## Requirements
- R1: After reset, pc_o reads 0x10, ie_o is 0, and inta_o, busy_o and rf_we_o are all 0.
- R2: A pulse on ei_i sets ie_o to 1 from the next cycle on. A pulse on di_i clears ie_o to 0 from the next cycle on.
- R3: When fetch_start_i is high and either ie_o is 0 or int_line_i is 0, no_int_o is high in that same cycle, busy_o stays 0 and pc_o is unchanged.
- R4: When fetch_start_i is high while ie_o and int_line_i are both 1, no_int_o is 0. In the next cycle rf_we_o is 1 for exactly one cycle, with rf_waddr_o = 12 and rf_wdata_o equal to pc_o. ie_o reads 0 from the cycle after that.
- R5: inta_o is high for exactly one cycle: the second cycle of the entry sequence. In that cycle mem_rd_o is 1 and mem_addr_o carries the device ID taken from io_data_i.
- R6: busy_o is high for exactly the three entry cycles. In the cycle after the third one, pc_o equals the word returned on mem_rdata_i during the acknowledge cycle, with the floor of R7 applied.
- R7: Whenever the stored PC is below 0x10, pc_o reads 0x10. Values of 0x10 and above pass through unchanged.
- R8: A pulse on reti_i loads the PC from k0_i and sets ie_o to 1, both visible in the next cycle.
- R9: mem_addr_o is the low 24 bits of the device ID. The upper 8 bits of io_data_i have no effect on it.
- R10: A pulse on pc_ld_i, with no return instruction in the same cycle, loads pc_d_i into the PC, visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_start_i | input | 1 | First fetch state; asks for the interrupt decision |
| int_line_i | input | 1 | Shared interrupt request; tie low when no device drives it |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| k0_i | input | 32 | Current value of kernel register 12 |
| pc_ld_i | input | 1 | Ordinary PC load from the datapath |
| pc_d_i | input | 32 | Value for the ordinary PC load |
| io_data_i | input | 32 | I/O bus carrying the device ID during acknowledge |
| mem_rdata_i | input | 32 | Vector-table read data, same cycle as the address |
| no_int_o | output | 1 | No interrupt due; fetch continues |
| busy_o | output | 1 | Entry sequence in progress |
| inta_o | output | 1 | Interrupt acknowledge |
| mem_rd_o | output | 1 | Vector-table read strobe |
| mem_addr_o | output | 24 | Vector-table word address |
| rf_we_o | output | 1 | Kernel register write enable |
| rf_waddr_o | output | 4 | Register index for the write (always 12) |
| rf_wdata_o | output | 32 | Saved PC |
| pc_o | output | 32 | Program counter, floored at 0x10 |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The assertions take for granted that the instruction strobes and ordinary PC loads never arrive while busy_o is high. They also assume that fetch_start_i is not raised in the same cycle as any of those strobes, and that the vector memory answers in the same cycle as mem_rd_o. The directed tasks hold every strobe low from the start strobe until busy_o falls. The bench's memory model is combinational and computed from mem_addr_o, so the assumed read timing always holds.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_ACK  = 2'd2,
    ST_LOAD = 2'd3
  } entry_st_e;
endpackage

// File: rtl/intr_ie_reg.sv
module intr_ie_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic val_i,
  output logic ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ie_o <= 1'b0;
    else if (ld_i) ie_o <= val_i;
  end
endmodule

// File: rtl/intr_pc_reg.sv
module intr_pc_reg #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned FLOOR = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] FLOOR_V = XLEN'(FLOOR);

  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= FLOOR_V;
    else if (ld_i) pc_q <= d_i;
  end

  // stored value may sit in the vector table; the output never does
  assign pc_o = (pc_q < FLOOR_V) ? FLOOR_V : pc_q;
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            save_o,
  output logic            ack_o,
  output logic            load_o,
  output logic            busy_o,
  output logic [XLEN-1:0] vec_o
);
  entry_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_i) st_d = ST_SAVE;
      ST_SAVE: st_d = ST_ACK;
      ST_ACK:  st_d = ST_LOAD;
      ST_LOAD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_o <= '0;
    else if (ack_o) vec_o <= mem_rdata_i;
  end

  assign save_o = (st_q == ST_SAVE);
  assign ack_o  = (st_q == ST_ACK);
  assign load_o = (st_q == ST_LOAD);
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/intr_pc_ctrl.sv
module intr_pc_ctrl #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned AW    = 24,
  parameter int unsigned RIW   = 4,
  parameter int unsigned KREG  = 12,
  parameter int unsigned FLOOR = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_start_i,
  input  logic            int_line_i,
  input  logic            ei_i,
  input  logic            di_i,
  input  logic            reti_i,
  input  logic [XLEN-1:0] k0_i,
  input  logic            pc_ld_i,
  input  logic [XLEN-1:0] pc_d_i,
  input  logic [XLEN-1:0] io_data_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            no_int_o,
  output logic            busy_o,
  output logic            inta_o,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            rf_we_o,
  output logic [RIW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic [XLEN-1:0] pc_o,
  output logic            ie_o
);
  logic            on_int, go;
  logic            save, ack, load, busy;
  logic [XLEN-1:0] vec;
  logic            ie_ld, ie_val;
  logic            pc_ld;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] io_bus;
  logic            unused_io_hi;

  assign on_int   = ie_o & int_line_i;
  assign go       = fetch_start_i & on_int;
  assign no_int_o = fetch_start_i & ~on_int & ~busy;

  intr_entry_seq #(.XLEN(XLEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .mem_rdata_i (mem_rdata_i),
    .save_o      (save),
    .ack_o       (ack),
    .load_o      (load),
    .busy_o      (busy),
    .vec_o       (vec)
  );

  // entry clear wins over any instruction strobe
  assign ie_ld  = save | (~busy & (ei_i | di_i | reti_i));
  assign ie_val = ~save & (ei_i | reti_i);

  intr_ie_reg u_ie (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ie_ld),
    .val_i  (ie_val),
    .ie_o   (ie_o)
  );

  assign pc_ld = load | (~busy & (reti_i | pc_ld_i));
  assign pc_d  = load ? vec : (reti_i ? k0_i : pc_d_i);

  intr_pc_reg #(.XLEN(XLEN), .FLOOR(FLOOR)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (pc_ld),
    .d_i    (pc_d),
    .pc_o   (pc_o)
  );

  // I/O bus reaches the main bus only while the acknowledge drives it
  assign io_bus       = ack ? io_data_i : '0;
  assign unused_io_hi = ^io_bus[XLEN-1:AW];
  assign mem_addr_o   = io_bus[AW-1:0];
  assign mem_rd_o     = ack;
  assign inta_o       = ack;
  assign busy_o       = busy;

  assign rf_we_o    = save;
  assign rf_waddr_o = RIW'(KREG);
  assign rf_wdata_o = pc_o;
endmodule

// File: rtl/intr_pc_ctrl_chk.sv
module intr_pc_ctrl_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned AW    = 24,
  parameter int unsigned RIW   = 4,
  parameter int unsigned KREG  = 12,
  parameter int unsigned FLOOR = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_start_i,
  input logic            int_line_i,
  input logic            reti_i,
  input logic [XLEN-1:0] k0_i,
  input logic            pc_ld_i,
  input logic [XLEN-1:0] pc_d_i,
  input logic [XLEN-1:0] io_data_i,
  input logic [XLEN-1:0] mem_rdata_i,
  input logic            no_int_o,
  input logic            busy_o,
  input logic            inta_o,
  input logic            mem_rd_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            rf_we_o,
  input logic [RIW-1:0]  rf_waddr_o,
  input logic [XLEN-1:0] pc_o,
  input logic            ie_o
);
  localparam logic [XLEN-1:0] FLOOR_V = XLEN'(FLOOR);

  function automatic logic [XLEN-1:0] floor_f(input logic [XLEN-1:0] v);
    return (v < FLOOR_V) ? FLOOR_V : v;
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk_i) !rst_ni |-> pc_o == FLOOR_V && !ie_o && !busy_o); // R1
  AST_TAKE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_start_i && ie_o && int_line_i && !busy_o |=> rf_we_o && rf_waddr_o == RIW'(KREG)); // R4
  AST_NO_INT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_int_o |=> !busy_o); // R3
  AST_SAVE_CLEARS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !ie_o); // R4
  AST_ACK_AFTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> inta_o && mem_rd_o); // R5
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> !inta_o && busy_o); // R5
  AST_ADDR_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> mem_addr_o == io_data_i[AW-1:0]); // R9
  AST_VECTOR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inta_o, 2) |-> pc_o == floor_f($past(mem_rdata_i, 2)) && !busy_o); // R6
  AST_RETI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !busy_o |=> ie_o && pc_o == floor_f($past(k0_i))); // R8
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ld_i && !reti_i && !busy_o |=> pc_o == floor_f($past(pc_d_i))); // R10
endmodule

bind intr_pc_ctrl intr_pc_ctrl_chk #(
  .XLEN(XLEN), .AW(AW), .RIW(RIW), .KREG(KREG), .FLOOR(FLOOR)
) u_chk (.*);

// File: tb/intr_pc_ctrl_tb.sv
module intr_pc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_start = 0, int_line = 0, ei = 0, di = 0, reti = 0, pc_ld = 0;
  logic [31:0] k0 = '0, pc_d = '0, io_data = '0, mem_rdata;
  logic        no_int, busy, inta, mem_rd, rf_we, ie;
  logic [23:0] mem_addr;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata, pc;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  // vector memory model: entry 5 points into the table on purpose
  always_comb mem_rdata = (mem_addr == 24'd5) ? 32'h3 : (32'h100 + {8'h0, mem_addr} * 4);

  intr_pc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_start_i(fetch_start), .int_line_i(int_line),
    .ei_i(ei), .di_i(di), .reti_i(reti), .k0_i(k0), .pc_ld_i(pc_ld), .pc_d_i(pc_d),
    .io_data_i(io_data), .mem_rdata_i(mem_rdata), .no_int_o(no_int), .busy_o(busy),
    .inta_o(inta), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .pc_o(pc), .ie_o(ie)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe_ei();
    ei = 1; step(); ei = 0;
  endtask

  task automatic test_reset();
    chk("R1 pc", pc, 32'h10);
    chk("R1 ie", {31'b0, ie}, 0);
    chk("R1 inta", {31'b0, inta}, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 rf_we", {31'b0, rf_we}, 0);
  endtask

  task automatic test_ie_instr();
    strobe_ei();
    chk("R2 ei", {31'b0, ie}, 1);
    di = 1; step(); di = 0;
    chk("R2 di", {31'b0, ie}, 0);
  endtask

  task automatic test_pc_load();
    pc_ld = 1; pc_d = 32'h7; step(); pc_ld = 0;
    chk("R7 below floor", pc, 32'h10);
    pc_ld = 1; pc_d = 32'h11; step(); pc_ld = 0;
    chk("R10 pc load", pc, 32'h11);
    pc_ld = 1; pc_d = 32'h10; step(); pc_ld = 0;
    chk("R7 at floor", pc, 32'h10);
    pc_ld = 1; pc_d = 32'h200; step(); pc_ld = 0;
    chk("R10 pc load high", pc, 32'h200);
  endtask

  task automatic test_no_int();
    // ie=0, line high
    int_line = 1; fetch_start = 1; #1;
    chk("R3 ie off", {31'b0, no_int}, 1);
    step(); fetch_start = 0;
    chk("R3 no busy", {31'b0, busy}, 0);
    chk("R3 pc kept", pc, 32'h200);
    strobe_ei();
    int_line = 0; fetch_start = 1; #1;
    chk("R3 line low", {31'b0, no_int}, 1);
    step(); fetch_start = 0;
    chk("R3 no busy 2", {31'b0, busy}, 0);
  endtask

  task automatic run_entry(input logic [31:0] id, input logic [31:0] exp_pc, input string tag);
    logic [31:0] pc0;
    pc0 = pc;
    int_line = 1; io_data = id; fetch_start = 1; #1;
    chk({tag, " R4 no_int low"}, {31'b0, no_int}, 0);
    step(); fetch_start = 0;
    chk({tag, " R4 save we"}, {31'b0, rf_we}, 1);
    chk({tag, " R4 save idx"}, {28'b0, rf_waddr}, 12);
    chk({tag, " R4 save data"}, rf_wdata, pc0);
    chk({tag, " R5 no ack yet"}, {31'b0, inta}, 0);
    step();
    chk({tag, " R4 ie cleared"}, {31'b0, ie}, 0);
    chk({tag, " R5 ack"}, {31'b0, inta}, 1);
    chk({tag, " R5 rd"}, {31'b0, mem_rd}, 1);
    chk({tag, " R9 addr"}, {8'b0, mem_addr}, {8'b0, id[23:0]});
    chk({tag, " R4 we once"}, {31'b0, rf_we}, 0);
    step(); int_line = 0;
    chk({tag, " R5 ack once"}, {31'b0, inta}, 0);
    chk({tag, " R6 busy 3rd"}, {31'b0, busy}, 1);
    step();
    chk({tag, " R6 busy done"}, {31'b0, busy}, 0);
    chk({tag, " R6 pc vec"}, pc, exp_pc);
  endtask

  task automatic test_reti();
    k0 = 32'h1234; reti = 1; step(); reti = 0;
    chk("R8 pc", pc, 32'h1234);
    chk("R8 ie", {31'b0, ie}, 1);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    test_reset();
    rst_n = 1; step();
    test_reset();
    test_ie_instr();
    test_pc_load();
    test_no_int();
    // ie is 1 now
    run_entry(32'hAB00_0003, 32'h10C, "E1");
    // line still high after entry but ie cleared: no interrupt
    int_line = 1; fetch_start = 1; #1;
    chk("R3 after entry", {31'b0, no_int}, 1);
    step(); fetch_start = 0; int_line = 0;
    test_reti();
    run_entry(32'hFF00_0005, 32'h10, "E2");
    strobe_ei();
    run_entry(32'h0000_0020, 32'h180, "E3");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule